// File: doc/BRIEF.md
# Memory-Mapped Pin Controller with Edge Capture

This block is a general-purpose pin controller for up to 32 pins, reached through a simple synchronous register bus. Software sets each pin's direction and drives output levels. It reads back a merged view of the pins: the output latch for driven pins and the synchronized pad value for the other pins. A single interrupt line reports pin activity, filtered by a per-pin enable mask.

The interrupt trigger is chosen when the block is built and cannot be changed while it runs. There are four choices: rising edge, falling edge, either edge, or level-high. In the three edge choices, each qualifying transition sets a sticky bit in a capture register. Software clears that bit by writing a one to it. In level-high mode nothing is latched, and the interrupt follows the live pin view gated by the mask.

Top module: `gpio_edge_cap`

## Requirements
- R1: After reset, the output latch, direction, mask and capture registers all read 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: Register select uses address bits [3:2]: 0x0 data, 0x4 direction, 0x8 mask, 0xC capture. Read data appears on `bus_rdata` one clock after the cycle with `bus_re` high, and holds until the next read. Bits at and above the pin count read as 0, and writes to them have no effect.
- R3: Direction bit 1 makes a pin an output and bit 0 an input. `pin_oe` equals the direction register and `pin_out` equals the output latch.
- R4: A data read returns the latch bit for output pins and the synchronized pad bit for input pins. A data write changes only the output latch.
- R5: Pads pass through two flops. In the edge modes a pad change sets its capture bit on the third rising clock edge after the change. In level mode the synchronized value reaches `irq` on the second edge.
- R6: The rising mode captures 0-to-1 transitions only, the falling mode 1-to-0 only, and the both mode captures either.
- R7: A write to the capture register clears each bit written as 1. Bits written as 0 keep their value.
- R8: If a new edge and a clearing write hit the same capture bit in the same cycle, the bit stays set.
- R9: Capture bits latch edges even when their mask bit is 0. Setting the mask bit later raises `irq` at once.
- R10: In the edge modes, `irq` is high exactly when some capture bit and its mask bit are both 1.
- R11: In level mode, `irq` is high while some bit of the data-read view AND the mask is 1, with no latching, and the capture register always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | N_PINS | Pad input values |
| pin_out | output | N_PINS | Output latch toward the pads |
| pin_oe | output | N_PINS | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check four properties on every cycle. A detected edge always leaves its capture bit set on the next cycle. A capture bit falls only when a one was written to it. A data write lands in the output latch. In level mode the capture register stays empty and any interrupt implies a non-zero mask. Some behaviours can only be shown by the bench's scenarios, which run four builds side by side, one per trigger choice. These are the exact synchronizer latency, which transitions each trigger choice keeps, the merged data view, the edge-beats-clear collision, and an interrupt that stays pending until unmasked.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    // word index taken from address bits [3:2]
    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_DIR  = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;
    localparam logic [1:0] SEL_CAP  = 2'd3;

    localparam int BUS_W = 32;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pad_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign rise_o = st_q.cur & ~st_q.prev;
    assign fall_o = ~st_q.cur & st_q.prev;

endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
    parameter int             N    = 32,
    parameter gpio_pkg::trig_e TRIG = gpio_pkg::TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] fall_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] cap_o
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [N-1:0] cap;
    } cap_t;

    cap_t         st_d, st_q;
    logic [N-1:0] edge_ev;

    always_comb begin
        unique case (TRIG)
            TRIG_RISE: edge_ev = rise_i;
            TRIG_FALL: edge_ev = fall_i;
            TRIG_BOTH: edge_ev = rise_i | fall_i;
            default:   edge_ev = '0;
        endcase
    end

    // a fresh edge outranks a clear in the same cycle
    always_comb begin
        st_d     = st_q;
        st_d.cap = (st_q.cap & ~clr_i) | edge_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o = st_q.cap;

    assert_cap_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev != '0) |=> ((st_q.cap & $past(edge_ev)) == $past(edge_ev)));

    assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(st_q.cap) & ~$past(clr_i)) & ~st_q.cap) == '0));

    assert_level_nocap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (TRIG == TRIG_LEVEL) |-> (st_q.cap == '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int N      = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    input  logic              re_i,
    input  logic [N-1:0]      pad_sync_i,
    input  logic [N-1:0]      cap_i,
    output logic [31:0]       rdata_o,
    output logic [N-1:0]      out_o,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      view_o,
    output logic [N-1:0]      cap_clr_o
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [N-1:0] outl;
        logic [N-1:0] dir;
        logic [N-1:0] mask;
        logic [31:0]  rdata;
    } regs_t;

    regs_t        st_d, st_q;
    logic [1:0]   sel;
    logic [N-1:0] wlo;
    logic [N-1:0] view;
    logic [N-1:0] rsel;
    logic [31:0]  unused_hi;

    assign sel       = addr_i[3:2];
    assign wlo       = wdata_i[N-1:0];
    assign unused_hi = wdata_i ^ {{(32-ADDR_W){1'b0}}, addr_i};
    assign view      = (st_q.outl & st_q.dir) | (pad_sync_i & ~st_q.dir);

    always_comb begin
        unique case (sel)
            SEL_DATA: rsel = view;
            SEL_DIR:  rsel = st_q.dir;
            SEL_MASK: rsel = st_q.mask;
            default:  rsel = cap_i;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            unique case (sel)
                SEL_DATA: st_d.outl = wlo;
                SEL_DIR:  st_d.dir  = wlo;
                SEL_MASK: st_d.mask = wlo;
                default:  ;
            endcase
        end
        if (re_i) begin
            st_d.rdata         = '0;
            st_d.rdata[N-1:0]  = rsel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o   = st_q.rdata;
    assign out_o     = st_q.outl;
    assign dir_o     = st_q.dir;
    assign mask_o    = st_q.mask;
    assign view_o    = view;
    assign cap_clr_o = (we_i && sel == SEL_CAP) ? wlo : '0;

    assert_out_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == SEL_DATA) |=> (st_q.outl == $past(wlo)));

endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap #(
    parameter int              N_PINS = 32,
    parameter int              ADDR_W = 4,
    parameter gpio_pkg::trig_e TRIG   = gpio_pkg::TRIG_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);
    import gpio_pkg::*;

    logic [N_PINS-1:0] cur, rise, fall, cap, clr, mask, view;

    gpio_in_sync #(.N(N_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_i(pin_in),
        .cur_o(cur), .rise_o(rise), .fall_o(fall)
    );

    gpio_capture #(.N(N_PINS), .TRIG(TRIG)) u_cap (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
        .clr_i(clr), .cap_o(cap)
    );

    gpio_regs #(.N(N_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
        .wdata_i(bus_wdata), .re_i(bus_re), .pad_sync_i(cur), .cap_i(cap),
        .rdata_o(bus_rdata), .out_o(pin_out), .dir_o(pin_oe),
        .mask_o(mask), .view_o(view), .cap_clr_o(clr)
    );

    generate
        if (TRIG == TRIG_LEVEL) begin : g_level
            assign irq = |(view & mask);
        end else begin : g_edge
            assign irq = |(cap & mask);
        end
    endgenerate

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0));

endmodule

// File: tb/tb_gpio_edge_cap.sv
module tb_gpio_edge_cap;
    import gpio_pkg::*;

    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    addr = '0;
    logic          we = 1'b0, re = 1'b0;
    logic [31:0]   wdata = '0;
    logic [N-1:0]  pins = '0;
    logic [31:0]   rd [4];
    logic          irqv [4];
    logic [N-1:0]  pout [4];
    logic [N-1:0]  poe [4];
    logic [31:0]   rs [4];
    int            n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    gpio_edge_cap #(.N_PINS(N), .TRIG(TRIG_RISE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rd[0]), .pin_in(pins), .pin_out(pout[0]),
        .pin_oe(poe[0]), .irq(irqv[0]));
    gpio_edge_cap #(.N_PINS(N), .TRIG(TRIG_FALL)) dut_f (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rd[1]), .pin_in(pins), .pin_out(pout[1]),
        .pin_oe(poe[1]), .irq(irqv[1]));
    gpio_edge_cap #(.N_PINS(N), .TRIG(TRIG_BOTH)) dut_b (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rd[2]), .pin_in(pins), .pin_out(pout[2]),
        .pin_oe(poe[2]), .irq(irqv[2]));
    gpio_edge_cap #(.N_PINS(N), .TRIG(TRIG_LEVEL)) dut_l (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rd[3]), .pin_in(pins), .pin_out(pout[3]),
        .pin_oe(poe[3]), .irq(irqv[3]));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rdall(input logic [3:0] a);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        for (int m = 0; m < 4; m++) rs[m] = rd[m];
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rdall(4'(a * 4));
            for (int m = 0; m < 4; m++) chk("R1", rs[m], 32'h0);
        end
        chk("R1", {pout[0], poe[0], 7'd0, irqv[0]}, 32'h0);

        // R3 direction and output drive; R2 upper bits ignored
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h0, 32'hFFFF_FFFA);
        chk("R3", {28'd0, poe[0]}, 32'hF);
        chk("R3", {28'd0, pout[0]}, 32'hA);
        rdall(4'h4);
        chk("R2", rs[0], 32'h0000_000F);
        rdall(4'h0);
        chk("R4", rs[0], 32'h0000_000A);
        // R2 bus_rdata holds without a read
        addr = 4'h8; idle(2);
        chk("R2", rd[0], 32'h0000_000A);

        // R4 merged view: pins 0,1 out, 2,3 in
        wr(4'h4, 32'h3);
        pins = 4'b0100;
        idle(3);
        rdall(4'h0);
        chk("R4", rs[0], ((32'hA & 32'h3) | (32'h4 & 32'hC)));
        chk("R3", {28'd0, pout[0]}, 32'hA);
        wr(4'h4, 32'h0);
        pins = '0; idle(4);
        wr(4'hC, 32'hF);

        // R6 sweep: each pin, each transition, each trigger build
        for (int p = 0; p < N; p++) begin
            pins[p] = 1'b1;
            idle(3);
            rdall(4'hC);
            for (int m = 0; m < 4; m++)
                chk("R6", rs[m], (m == 0 || m == 2) ? (32'h1 << p) : 32'h0);
            pins[p] = 1'b0;
            idle(3);
            rdall(4'hC);
            for (int m = 0; m < 4; m++)
                chk(m == 3 ? "R11" : "R6", rs[m], (m == 3) ? 32'h0 : (32'h1 << p));
            // R7 write zero keeps, write one clears
            wr(4'hC, 32'h0);
            rdall(4'hC);
            chk("R7", rs[2], 32'h1 << p);
            wr(4'hC, 32'h1 << p);
            rdall(4'hC);
            for (int m = 0; m < 4; m++) chk("R7", rs[m], 32'h0);
        end

        // R8 edge collides with clear
        pins = 4'b0001; idle(3);
        pins = 4'b0011; idle(2);
        wr(4'hC, 32'h3);
        rdall(4'hC);
        chk("R8", rs[0], 32'h2);
        chk("R8", rs[2], 32'h2);
        chk("R8", rs[1], 32'h0);
        pins = '0; idle(4);
        wr(4'hC, 32'hF);

        // R5 latency and R10 irq
        wr(4'h8, 32'hF);
        pins = 4'b1000;
        idle(2);
        chk("R5", {31'd0, irqv[0]}, 32'h0);
        idle(1);
        chk("R5", {31'd0, irqv[0]}, 32'h1);
        chk("R10", {31'd0, irqv[1]}, 32'h0);
        wr(4'hC, 32'h8);
        chk("R10", {31'd0, irqv[0]}, 32'h0);
        pins = '0; idle(4);
        wr(4'hC, 32'hF);

        // R9 pending while masked
        wr(4'h8, 32'h0);
        pins = 4'b0100; idle(3);
        chk("R9", {31'd0, irqv[0]}, 32'h0);
        rdall(4'hC);
        chk("R9", rs[0], 32'h4);
        wr(4'h8, 32'h8);
        chk("R10", {31'd0, irqv[0]}, 32'h0);
        wr(4'h8, 32'h4);
        chk("R9", {31'd0, irqv[0]}, 32'h1);
        pins = '0; idle(4);
        wr(4'hC, 32'hF);

        // R11 level mode follows live view
        wr(4'h8, 32'h2);
        pins = 4'b0010;
        idle(1);
        chk("R11", {31'd0, irqv[3]}, 32'h0);
        idle(1);
        chk("R11", {31'd0, irqv[3]}, 32'h1);
        pins = 4'b0001; idle(2);
        chk("R11", {31'd0, irqv[3]}, 32'h0);
        pins = '0;
        wr(4'h0, 32'h2);
        wr(4'h4, 32'h2);
        chk("R11", {31'd0, irqv[3]}, 32'h1);
        rdall(4'hC);
        chk("R11", rs[3], 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule